// File: doc/BRIEF.md
# Processor Status Word Unit with Privilege and Trace Control

This block holds the 32-bit processor status word of a small in-order core and applies every rule that governs how that word changes when an instruction completes. Each cycle the core reports at most one completion event: an ordinary instruction, a software write to the status word, a write aimed at a high global register, or a return that carries a saved status word and a saved PC. An exception entry can also be reported, with or without a completion. The block updates the word on the clock edge and raises a one-cycle privilege-trap pulse or trace-exception pulse when the rules call for one.

The word's low half is the only part software can write. The upper half holds the trace, trace-pending, supervisor and instruction-length fields, which only a return reloads in full. A one-shot high-bank flag lets the next instruction reach registers 16..31 through codes 0..15. Flag generation in the ALU and the register file belong to other blocks. Only the write enable for the high registers is gated here.

Field positions (bit index in the word): high-bank 5, interrupt lock 15, trace mode 16, trace pending 17, supervisor 18, instruction length 20..19.

Top module: `status_word_unit`

## Requirements
- R1: After reset the word reads 0x0004_8000, with supervisor and lock set and every other bit 0. Both pulse outputs are low.
- R2: A software write (no exception) replaces bits 15..0 with `wr_data_i`. Bits 31..21, 18 and 16 keep their values.
- R3: The high-bank flag (bit 5) is set only by a software write with data bit 5 set. The next completion or exception entry clears it, and `hbank_o` mirrors it.
- R4: A high-register write with supervisor = 0 drives `hireg_we_o` low in the same cycle and raises `priv_trap_o` in the following cycle. With supervisor = 1, `hireg_we_o` is high and no trap is raised.
- R5: In user state, a software write that changes the lock from 0 to 1 raises a privilege trap. The same write in supervisor state does not.
- R6: An exception entry sets bits 15 and 18 and clears bits 16 and 5. It leaves every other bit unchanged, discards any completion in the same cycle, and raises neither pulse.
- R7: A return loads the word from `ret_sr_i`, takes bit 18 from `ret_pc0_i`, and clears bits 20..19 and bit 5. It traps if it goes from user state to supervisor state, or if it returns to user state with saved lock = 1.
- R8: Every non-return completion sets bit 17 and writes `ilen_i` (1, 2 or 3 half-words) into bits 20..19. A return instead loads bit 17 from the saved word.
- R9: `trace_req_o` pulses in the cycle after a completion whose updated word has bits 16 and 17 both set. A delayed branch (`dly_br_i`) suppresses the pulse.
- R10: When a privilege trap and a trace request arise together, only `priv_trap_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | An instruction completes this cycle |
| ilen_i | input | 2 | Length of the completing instruction in half-words |
| wr_sw_i | input | 1 | Completion is a software write of the low half |
| wr_data_i | input | 16 | Data for the low half |
| hireg_wr_i | input | 1 | Completion writes a high global register |
| ret_i | input | 1 | Completion is a return |
| ret_sr_i | input | 32 | Saved status word for the return |
| ret_pc0_i | input | 1 | Bit 0 of the saved PC, giving the new supervisor flag |
| dly_br_i | input | 1 | Completion is a delayed branch |
| exc_i | input | 1 | Exception entry this cycle |
| sr_o | output | 32 | Current status word |
| hbank_o | output | 1 | High-bank remap active for the next instruction |
| hireg_we_o | output | 1 | Permitted high-register write |
| priv_trap_o | output | 1 | Privilege trap pulse |
| trace_req_o | output | 1 | Trace exception pulse |

## Verification
The bench drives the privilege cases that a design could easily get wrong. It sets the lock from user state and checks that the same write from supervisor state does not trap. It returns into supervisor state from user state, and returns to user state with the saved lock set. A design that took the supervisor flag from the saved word instead of the PC bit, or that compared against the new state instead of the old, would miss the trap or raise a false one. The bench lets the high-bank flag survive for exactly one instruction. It arms trace through a return and fires it on the following instructions. It then checks that a delayed branch, an exception or a coincident privilege trap silences the trace pulse. A design with a wrong priority would raise both pulses together.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned SR_W   = 32;
  localparam int unsigned LO_W   = 16;
  localparam int unsigned ILEN_W = 2;
  localparam int unsigned HB_B   = 5;
  localparam int unsigned LK_B   = 15;
  localparam int unsigned TM_B   = 16;
  localparam int unsigned TP_B   = 17;
  localparam int unsigned SV_B   = 18;
  localparam int unsigned IL_LO  = 19;
  localparam logic [SR_W-1:0] SR_RST = (SR_W'(1) << SV_B) | (SR_W'(1) << LK_B);
endpackage

// File: rtl/sw_next.sv
module sw_next
  import sw_pkg::*;
(
  input  logic [SR_W-1:0]   sr_q_i,
  input  logic              done_i,
  input  logic              exc_i,
  input  logic              wr_sw_i,
  input  logic [LO_W-1:0]   wr_data_i,
  input  logic              ret_i,
  input  logic [SR_W-1:0]   ret_sr_i,
  input  logic              ret_pc0_i,
  input  logic [ILEN_W-1:0] ilen_i,
  output logic [SR_W-1:0]   sr_d_o
);
  always_comb begin
    sr_d_o = sr_q_i;
    if (exc_i) begin
      sr_d_o[LK_B] = 1'b1;
      sr_d_o[SV_B] = 1'b1;
      sr_d_o[TM_B] = 1'b0;
      sr_d_o[HB_B] = 1'b0;
    end else if (done_i) begin
      if (ret_i) begin
        sr_d_o                   = ret_sr_i;
        sr_d_o[SV_B]             = ret_pc0_i;
        sr_d_o[IL_LO +: ILEN_W]  = '0;
        sr_d_o[HB_B]             = 1'b0;
      end else begin
        sr_d_o[HB_B] = 1'b0;          // one-shot: consumed by this instruction
        if (wr_sw_i) sr_d_o[LO_W-1:0] = wr_data_i;
        sr_d_o[TP_B]            = 1'b1;
        sr_d_o[IL_LO +: ILEN_W] = ilen_i;
      end
    end
  end
endmodule

// File: rtl/sw_priv.sv
module sw_priv (
  input  logic sv_i,
  input  logic lock_i,
  input  logic done_i,
  input  logic exc_i,
  input  logic wr_sw_i,
  input  logic wr_lock_i,
  input  logic hireg_wr_i,
  input  logic ret_i,
  input  logic ret_pc0_i,
  input  logic ret_lock_i,
  output logic trap_o,
  output logic hireg_we_o
);
  logic live, lock_set, hi_bad, ret_bad;
  always_comb begin
    live       = done_i && !exc_i;
    lock_set   = wr_sw_i && !ret_i && !sv_i && !lock_i && wr_lock_i;
    hi_bad     = hireg_wr_i && !ret_i && !sv_i;
    ret_bad    = ret_i && ((!sv_i && ret_pc0_i) || (!ret_pc0_i && ret_lock_i));
    trap_o     = live && (lock_set || hi_bad || ret_bad);
    hireg_we_o = live && hireg_wr_i && !ret_i && sv_i;
  end
endmodule

// File: rtl/sw_trace.sv
module sw_trace (
  input  logic done_i,
  input  logic exc_i,
  input  logic dly_br_i,
  input  logic trap_i,
  input  logic tm_new_i,
  input  logic tp_new_i,
  output logic trace_o
);
  // trap outranks trace
  assign trace_o = done_i && !exc_i && !dly_br_i && !trap_i && tm_new_i && tp_new_i;
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
  import sw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [1:0]        ilen_i,
  input  logic              wr_sw_i,
  input  logic [15:0]       wr_data_i,
  input  logic              hireg_wr_i,
  input  logic              ret_i,
  input  logic [31:0]       ret_sr_i,
  input  logic              ret_pc0_i,
  input  logic              dly_br_i,
  input  logic              exc_i,
  output logic [31:0]       sr_o,
  output logic              hbank_o,
  output logic              hireg_we_o,
  output logic              priv_trap_o,
  output logic              trace_req_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic trap_d, trace_d;

  sw_next u_next (
    .sr_q_i(sr_q), .done_i(done_i), .exc_i(exc_i), .wr_sw_i(wr_sw_i),
    .wr_data_i(wr_data_i), .ret_i(ret_i), .ret_sr_i(ret_sr_i),
    .ret_pc0_i(ret_pc0_i), .ilen_i(ilen_i), .sr_d_o(sr_d)
  );

  sw_priv u_priv (
    .sv_i(sr_q[SV_B]), .lock_i(sr_q[LK_B]), .done_i(done_i), .exc_i(exc_i),
    .wr_sw_i(wr_sw_i), .wr_lock_i(wr_data_i[LK_B]), .hireg_wr_i(hireg_wr_i),
    .ret_i(ret_i), .ret_pc0_i(ret_pc0_i), .ret_lock_i(ret_sr_i[LK_B]),
    .trap_o(trap_d), .hireg_we_o(hireg_we_o)
  );

  sw_trace u_trace (
    .done_i(done_i), .exc_i(exc_i), .dly_br_i(dly_br_i), .trap_i(trap_d),
    .tm_new_i(sr_d[TM_B]), .tp_new_i(sr_d[TP_B]), .trace_o(trace_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= SR_RST;
      priv_trap_o <= 1'b0;
      trace_req_o <= 1'b0;
    end else begin
      sr_q        <= sr_d;
      priv_trap_o <= trap_d;
      trace_req_o <= trace_d;
    end
  end

  assign sr_o    = sr_q;
  assign hbank_o = sr_q[HB_B];

  a_r2_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && wr_sw_i && !ret_i && !exc_i) |=>
      (sr_q[31:21] == $past(sr_q[31:21]) && sr_q[SV_B] == $past(sr_q[SV_B])
       && sr_q[TM_B] == $past(sr_q[TM_B])));
  a_r3_hbank_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_i || exc_i) && !(wr_sw_i && wr_data_i[HB_B] && !exc_i && !ret_i)) |=> !hbank_o);
  a_r4_hireg_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !exc_i && hireg_wr_i && !ret_i && !sr_o[SV_B]) |-> (!hireg_we_o ##1 priv_trap_o));
  a_r6_exc_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> (sr_o[LK_B] && sr_o[SV_B] && !sr_o[TM_B] && !priv_trap_o && !trace_req_o));
  a_r9_dly_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dly_br_i) |=> !trace_req_o);
  a_r10_trap_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(priv_trap_o && trace_req_o));
endmodule

// File: tb/status_word_unit_bench.sv
module status_word_unit_bench;
  localparam int CLK_P = 10;
  localparam int K_IDLE = 0, K_PLAIN = 1, K_SW = 2, K_HI = 3, K_RET = 4, K_EXC = 5, K_EXC_DONE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done, wr_sw, hireg_wr, ret, ret_pc0, dly_br, exc;
  logic [1:0] ilen;
  logic [15:0] wr_data;
  logic [31:0] ret_sr, sr;
  logic hbank, hireg_we, trap, trace;

  always #(CLK_P/2) clk = ~clk;

  status_word_unit u_status_word_unit (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .ilen_i(ilen), .wr_sw_i(wr_sw),
    .wr_data_i(wr_data), .hireg_wr_i(hireg_wr), .ret_i(ret), .ret_sr_i(ret_sr),
    .ret_pc0_i(ret_pc0), .dly_br_i(dly_br), .exc_i(exc), .sr_o(sr), .hbank_o(hbank),
    .hireg_we_o(hireg_we), .priv_trap_o(trap), .trace_req_o(trace)
  );

  typedef struct { logic [31:0] sr; logic trap; logic trace; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic [31:0] m_sr;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, model expected results from the requirements
  task automatic step(input int k, input logic [15:0] d, input logic [1:0] il,
                      input logic [31:0] rs, input logic pc0, input logic db, input string tag);
    exp_t e;
    logic [31:0] n;
    logic tp, we_exp;
    @(negedge clk);
    done = (k != K_IDLE && k != K_EXC); wr_sw = (k == K_SW); wr_data = d;
    hireg_wr = (k == K_HI); ret = (k == K_RET); ret_sr = rs; ret_pc0 = pc0;
    dly_br = db; ilen = il; exc = (k == K_EXC || k == K_EXC_DONE);
    n = m_sr; tp = 1'b0; we_exp = 1'b0;
    if (exc) begin
      n[15] = 1; n[18] = 1; n[16] = 0; n[5] = 0;                       // R6
    end else if (k == K_RET) begin
      n = rs; n[18] = pc0; n[20:19] = 2'b00; n[5] = 0;                 // R7
      tp = (!m_sr[18] && pc0) || (!pc0 && rs[15]);
    end else if (done) begin
      n[5] = 0;                                                        // R3
      if (k == K_SW) begin
        n[15:0] = d;                                                   // R2
        tp = !m_sr[18] && !m_sr[15] && d[15];                          // R5
      end
      if (k == K_HI) begin tp = !m_sr[18]; we_exp = m_sr[18]; end      // R4
      n[17] = 1; n[20:19] = il;                                        // R8
    end
    e.sr = n; e.trap = tp;
    e.trace = done && !exc && !db && !tp && n[16] && n[17];            // R9 R10
    e.tag = tag;
    m_sr = n;
    q.push_back(e);
    #1 chk({tag, " R4 hireg_we"}, {31'd0, hireg_we}, {31'd0, we_exp});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " word"},  sr, e.sr);
        chk({e.tag, " R3 hbank"}, {31'd0, hbank}, {31'd0, e.sr[5]});
        chk({e.tag, " trap"},  {31'd0, trap}, {31'd0, e.trap});
        chk({e.tag, " trace"}, {31'd0, trace}, {31'd0, e.trace});
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    done = 0; wr_sw = 0; wr_data = '0; hireg_wr = 0; ret = 0; ret_sr = '0;
    ret_pc0 = 0; dly_br = 0; exc = 0; ilen = 2'd1;
    m_sr = 32'h0004_8000;
    repeat (2) @(negedge clk);
    chk("R1 reset word", sr, 32'h0004_8000);
    chk("R1 reset pulses", {30'd0, trap, trace}, 32'd0);
    rst_n = 1'b1;
    step(K_SW,    16'h0020, 2'd1, '0, 0, 0, "R2 R3 sv write sets hbank");
    step(K_PLAIN, 16'h0000, 2'd2, '0, 0, 0, "R3 R8 hbank cleared ilen2");
    step(K_SW,    16'h8000, 2'd3, '0, 0, 0, "R5 sv lock set no trap");
    step(K_HI,    16'h0000, 2'd1, '0, 0, 0, "R4 sv hireg ok");
    step(K_RET,   16'h0000, 2'd1, 32'h00000000, 0, 0, "R7 ret to user");
    step(K_HI,    16'h0000, 2'd1, '0, 0, 0, "R4 user hireg trap");
    step(K_SW,    16'h8001, 2'd2, '0, 0, 0, "R5 user lock set trap");
    step(K_SW,    16'h0020, 2'd1, '0, 0, 0, "R3 user hbank set");
    step(K_EXC,   16'h0000, 2'd1, '0, 0, 0, "R6 R3 exception");
    step(K_RET,   16'h0000, 2'd1, 32'h00008000, 0, 0, "R7 ret user lock trap");
    step(K_RET,   16'h0000, 2'd1, 32'h00000000, 0, 0, "R7 ret user clean");
    step(K_RET,   16'h0000, 2'd1, 32'h00000000, 1, 0, "R7 user to sv trap");
    step(K_RET,   16'h0000, 2'd1, 32'h0019_0000, 1, 0, "R7 R9 ret arms trace");
    step(K_PLAIN, 16'h0000, 2'd1, '0, 0, 0, "R9 trace plain");
    step(K_PLAIN, 16'h0000, 2'd2, '0, 0, 1, "R9 delayed branch no trace");
    step(K_IDLE,  16'h0000, 2'd1, '0, 0, 0, "R9 idle no trace");
    step(K_RET,   16'h0000, 2'd1, 32'h0003_0000, 0, 0, "R7 R9 ret user traced");
    step(K_HI,    16'h0000, 2'd1, '0, 0, 0, "R10 trap over trace");
    step(K_EXC_DONE, 16'h00FF, 2'd3, '0, 0, 0, "R6 exc with completion");
    step(K_SW,    16'h1234, 2'd2, '0, 0, 0, "R2 R8 write after exc");
    step(K_IDLE,  16'h0000, 2'd1, '0, 0, 0, "R8 idle holds");
    step(K_IDLE,  16'h0000, 2'd1, '0, 0, 0, "drain");
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule